// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous system bus and an external asynchronous static RAM with an 18-bit word address and a 4-bit data word. It accepts one single-word request at a time over a valid/ready handshake. For each request it produces the active-low select, output-enable and write-strobe waveforms the memory expects. The bidirectional data pins are split into an output word, an output-enable and an input word, which the pad ring joins.

Every phase length comes from timing figures given in nanoseconds and from the clock period. The cycle count for a figure is the figure divided by the period, rounded up, and never less than one. The sequencer holds the address and write data in registers for the whole access. It captures read data in the last cycle of the access phase. It never drives the data pins while the memory may be driving them. A write that follows a read waits a turnaround period before its drivers turn on.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle, so at most one access is in flight. The request fields need only be stable on the transfer edge. The read response has no ready signal. `rsp_valid` is a single-cycle strobe, and the consumer must take `rsp_rdata` in that cycle.

Top module: `sram_seq`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are all 1 and `mem_dq_oe` is 0.
- R2: The cycle counts are RD_CYC = ceil(T_ACC_NS/CLK_NS), WR_CYC = ceil(max(T_WP_NS, T_DS_NS)/CLK_NS) and TA_CYC = ceil(T_TA_NS/CLK_NS). Each count is at least 1.
- R3: After an accepted read, `req_ready` stays low for RD_CYC+1 cycles. After an accepted write, it stays low for WR_CYC+1 cycles, or TA_CYC+WR_CYC+1 cycles when the previous access was a read.
- R4: A read holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with `mem_dq_oe`=0 for exactly RD_CYC cycles, starting the cycle after acceptance.
- R5: Read data is sampled from `mem_dq_in` at the end of the last read cycle. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, in the recovery cycle that follows.
- R6: A write holds `mem_cs_n`=0, `mem_we_n`=0 and `mem_oe_n`=1 for exactly WR_CYC cycles. During the whole pulse `mem_dq_oe`=1 and `mem_dq_out` is stable. The memory takes the word when `mem_we_n` rises.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. `mem_dq_oe` returns to 0 on the same edge where `mem_we_n` rises.
- R8: When a write follows a read, at least TA_CYC cycles pass between `mem_oe_n` rising and `mem_dq_oe` rising. During those cycles all controls are high.
- R9: `mem_addr` and the write word are registered on acceptance and stay stable while `mem_cs_n` is low. Changes on `req_addr` and `req_wdata` while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write word |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 18 | Memory address pins |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 4 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | 4 | Data received from the memory pins |

## Verification
The hardest case to reach from the ports is a write issued on the very edge where the sequencer turns idle after a read. Only then does the turnaround decide whether the drivers turn on while the memory output is still floating off. The bench holds its next request ready at the negative edge where `req_ready` returns. It sweeps alternating read/write pairs over many addresses, so each write is accepted with no idle cycle after the previous read. Its memory model returns the inverted word until the address has been stable for the full access time. With this model, a capture one cycle early shows up as wrong data.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_TURN  = 3'd1,
    PH_READ  = 3'd2,
    PH_WRITE = 3'd3,
    PH_RECOV = 3'd4
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } pins_t;

  // ceiling of ns/period, floor of one cycle
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic pins_t pins_for(input phase_e ph);
    pins_t p;
    p = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    case (ph)
      PH_READ:  begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
      PH_WRITE: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
      default:  ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));

  a_r2_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int RD_CYC = 5,
  parameter int WR_CYC = 4,
  parameter int TA_CYC = 2,
  localparam int CNT_W = $clog2(imax(imax(RD_CYC, WR_CYC), TA_CYC) + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  logic  req_write,
  output logic  req_ready,
  output logic  accept,
  output logic  capture,
  output pins_t pins
);

  phase_e state_q, state_d;
  pins_t  pins_q;
  logic   after_rd_q;
  logic   load;
  logic [CNT_W-1:0] load_val;
  logic   last;

  sram_phase_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last(last)
  );

  assign req_ready = (state_q == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (state_q == PH_READ) && last;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      PH_IDLE: if (accept) begin
        load = 1'b1;
        if (!req_write) begin
          state_d  = PH_READ;
          load_val = CNT_W'(RD_CYC);
        end else if (after_rd_q) begin
          state_d  = PH_TURN;
          load_val = CNT_W'(TA_CYC);
        end else begin
          state_d  = PH_WRITE;
          load_val = CNT_W'(WR_CYC);
        end
      end
      PH_TURN: if (last) begin
        state_d  = PH_WRITE;
        load     = 1'b1;
        load_val = CNT_W'(WR_CYC);
      end
      PH_READ, PH_WRITE: if (last) state_d = PH_RECOV;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PH_IDLE;
      pins_q     <= pins_for(PH_IDLE);
      after_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_for(state_d);
      if (capture)                     after_rd_q <= 1'b1;
      else if (state_d == PH_WRITE)    after_rd_q <= 1'b0;
    end
  end

  assign pins = pins_q;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (pins.cs_n && pins.oe_n && pins.we_n && !pins.dq_oe));
  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(pins.dq_oe && !pins.oe_n));
  a_r6_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !pins.we_n |-> !pins.cs_n);
  a_r7_release_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins.we_n) |-> !pins.dq_oe);
  a_r8_read_then_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins.oe_n) |-> !pins.dq_oe);

endmodule

// File: rtl/sram_seq_data.sv
module sram_seq_data #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              busy,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= mem_dq_in;
      rvld_q <= capture;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = rvld_q;
  assign rsp_rdata  = rdata_q;

  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wdata_q)));
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rvld_q |=> !rvld_q);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 4,
  parameter int CLK_NS   = 4,
  parameter int T_ACC_NS = 20,
  parameter int T_WP_NS  = 15,
  parameter int T_DS_NS  = 12,
  parameter int T_TA_NS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC = ns_to_cyc(T_ACC_NS, CLK_NS);
  localparam int WR_CYC = ns_to_cyc(imax(T_WP_NS, T_DS_NS), CLK_NS);
  localparam int TA_CYC = ns_to_cyc(T_TA_NS, CLK_NS);

  logic  accept, capture;
  pins_t pins;

  sram_seq_ctrl #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .capture(capture), .pins(pins)
  );

  sram_seq_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .busy(!pins.cs_n), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_dq_in(mem_dq_in), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign mem_cs_n  = pins.cs_n;
  assign mem_oe_n  = pins.oe_n;
  assign mem_we_n  = pins.we_n;
  assign mem_dq_oe = pins.dq_oe;

  a_r9_addr_stable_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_seq_tb_top.sv
module sram_seq_tb_top;

  localparam int AW = 18, DW = 4, PER = 4;
  localparam int E_RD = (20 + PER - 1) / PER;
  localparam int E_WR = (15 + PER - 1) / PER;
  localparam int E_TA = (8 + PER - 1) / PER;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata, mem_dq_out;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_in = '0;

  sram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and shadow
  logic [DW-1:0] mem [int];
  logic [DW-1:0] shadow [int];

  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    return a[3:0] ^ a[11:8] ^ 4'h5;
  endfunction
  function automatic logic [DW-1:0] mget(input logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : dflt(a);
  endfunction
  function automatic logic [DW-1:0] sget(input logic [AW-1:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
  endfunction

  int rd_age = 0, wp_age = 0, since_oe = 100;
  bit prev_rd = 0, prev_dq_oe = 0, ever_read = 0;
  logic [AW-1:0] prev_addr = '0, w_addr = '0;
  logic [DW-1:0] w_data = '0;
  int rsp_cnt = 0;
  logic [DW-1:0] rsp_last = '0;

  always @(negedge clk) if (rst_n && !finished) begin
    if (rsp_valid) begin rsp_cnt++; rsp_last = rsp_rdata; end
    // R1 quiet idle
    if (req_ready)
      chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle pins",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    // R7 contention
    if (mem_dq_oe && !mem_oe_n) chk(0, "R7 drive while oe low", 1, 0);
    // read access age
    if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
      rd_age = (prev_rd && mem_addr == prev_addr) ? rd_age + 1 : 1;
      ever_read = 1;
      if (mem_dq_oe) chk(0, "R4 driver on in read", 1, 0);
    end else rd_age = 0;
    prev_rd = (!mem_cs_n && !mem_oe_n && mem_we_n);
    prev_addr = mem_addr;
    mem_dq_in = (rd_age >= E_RD) ? mget(mem_addr) : ~mget(mem_addr);
    // R8 turnaround
    if (mem_dq_oe && !prev_dq_oe && ever_read)
      chk(since_oe >= E_TA + 1, "R8 turnaround gap", since_oe - 1, E_TA);
    if (!mem_oe_n) since_oe = 0; else if (since_oe < 100) since_oe++;
    prev_dq_oe = mem_dq_oe;
    // write strobe
    if (!mem_cs_n && !mem_we_n) begin
      if (!mem_oe_n) chk(0, "R6 oe low in write", 0, 1);
      if (!mem_dq_oe) chk(0, "R6 driver off in pulse", 0, 1);
      if (wp_age > 0 && (mem_dq_out != w_data || mem_addr != w_addr))
        chk(0, "R9 data/addr moved in pulse", int'(mem_dq_out), int'(w_data));
      wp_age++;
      w_data = mem_dq_out;
      w_addr = mem_addr;
    end else if (wp_age > 0) begin
      chk(wp_age == E_WR, "R6 pulse length", wp_age, E_WR);
      chk(!mem_dq_oe, "R7 release at strobe rise", int'(mem_dq_oe), 0);
      mem[int'(w_addr)] = w_data;
      wp_age = 0;
    end
  end

  bit last_rd = 0;

  // called at a negedge with req_ready expected; returns at negedge with ready high
  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat, expl, c0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    c0 = rsp_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~a; req_wdata = ~d; // R9 busy-time changes must be ignored
    lat = 1;
    while (!req_ready) begin @(negedge clk); lat++; end
    expl = wr ? (last_rd ? E_TA + E_WR + 1 : E_WR + 1) : E_RD + 1;
    chk(lat - 1 == expl, wr ? "R3 write busy length" : "R3 read busy length", lat - 1, expl);
    if (wr) begin
      shadow[int'(a)] = d;
      chk(rsp_cnt == c0, "R5 no strobe on write", rsp_cnt - c0, 0);
      last_rd = 0;
    end else begin
      chk(rsp_cnt - c0 == 1, "R5 one strobe per read", rsp_cnt - c0, 1);
      chk(rsp_last == sget(a), "R5 R4 read data", int'(rsp_last), int'(sget(a)));
      last_rd = 1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        "R1 reset state", {req_ready, mem_cs_n, mem_oe_n, mem_we_n}, 4'hf);
    rst_n = 1'b1;
    @(negedge clk);
    chk(E_RD == 5 && E_WR == 4 && E_TA == 2, "R2 derived counts", E_RD * 100 + E_WR * 10 + E_TA, 542);
    // unwritten reads
    for (int i = 0; i < 8; i++) xfer(0, AW'(i * 33391 + 7), '0);
    // write sweep, back to back writes
    for (int i = 0; i < 96; i++) xfer(1, AW'((i * 40503) & 18'h3ffff), DW'(i ^ (i >> 4)));
    // read back
    for (int i = 0; i < 96; i++) xfer(0, AW'((i * 40503) & 18'h3ffff), '0);
    // read immediately followed by write, all data values and address extremes
    for (int i = 0; i < 64; i++) begin
      logic [AW-1:0] a;
      a = (i[0]) ? AW'(18'h3ffff - i) : AW'(i << 12);
      xfer(0, a, '0);
      xfer(1, a, DW'(i));
      xfer(0, a, '0);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule